// File: doc/BRIEF.md
# Weighted-Field Grayscale Scan Sequencer

This block paces the refresh of a 1/16-scan LED matrix that shows 8-bit grayscale through bit planes. It generates the read address into an external bit-plane frame buffer and samples the returned data bits, one bit per output lane. The bits go out serially with a shift strobe. At the end of each row it pulses a row latch and updates the row select. For each latched row it drives an enable window whose length sets how long the LEDs stay lit for the bit plane being shown.

Bit planes are not visited in plain binary order. A frame has 19 fields. The most significant bit is shown in 8 consecutive fields, the next bit in 4 and the next in 2; bit 4 gets one field. Each of these fields is lit for the whole row time T. Bits 3 to 0 get one field each, lit for T/2, T/4, T/8 and T/16. Summed over a frame, each step of a pixel value therefore adds T/16 of lit time, and full scale reaches nearly 16T out of 19T. A row time is one pass of the column counter, which advances once per clock. The frame-buffer RAM and the LED drivers are outside the block.

Top module: `wfg_scan_seq`

## Requirements
- R1: While `rst_n` is low, `sd_out`, `cp_o`, `le_o`, `row_sel` and `ea_o` are 0. Column, row and field all restart at 0, so `rd_addr` holds plane 7 with row 0 and column 0.
- R2: The column counter advances by one on every clock after reset and wraps from COLS-1 to 0. The column sits in the low $clog2(COLS) bits of `rd_addr`.
- R3: The row counter sits in the next $clog2(ROWS) bits of `rd_addr`. It advances by one in the cycle after the column reaches COLS-1, and it wraps after ROWS rows. Each row wrap advances a field index 0..18, which wraps from 18 back to 0.
- R4: The bit plane sits in the top 3 bits of `rd_addr`. It is 7 for fields 0 to 7, 6 for fields 8 to 11, 5 for fields 12 and 13, and 18 minus the field index for fields 14 to 18.
- R5: `sd_out` in each cycle equals the `rd_bit` returned for the address presented one cycle earlier. `cp_o` is 0 in the first cycle after reset and 1 from then on.
- R6: `le_o` is a one-cycle pulse that occurs two cycles after each cycle in which the column is COLS-1. In the same cycle, `row_sel` takes the row of that cycle. `row_sel` changes at no other time.
- R7: `ea_o` rises in the cycle after an `le_o` pulse. It stays high for W cycles, where W depends only on the plane of the latched row: COLS for planes 7 to 4, and COLS/2, COLS/4, COLS/8 and COLS/16 for planes 3, 2, 1 and 0.
- R8: A new window cuts off any rest of the previous one. With full-width planes, `ea_o` therefore stays high without a gap from row to row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | output | 3+$clog2(ROWS)+$clog2(COLS) | Frame-buffer read address {plane, row, column} |
| rd_bit | input | LANES | Data bit per lane returned for `rd_addr` in the same cycle |
| sd_out | output | LANES | Serial data to the drivers |
| cp_o | output | 1 | Shift strobe, one bit per lane per cycle |
| le_o | output | 1 | Row latch pulse |
| row_sel | output | $clog2(ROWS) | Row select of the latched row |
| ea_o | output | 1 | Lit-time enable window |

## Verification
The bench uses a 16-column, 4-row configuration. It runs whole frames so that every field index, every plane and every enable width occurs, including the one-cycle window for plane 0. The frame buffer is modelled as an address-dependent bit pattern that differs per lane. Because of this, a wrong field order or a swapped address slice shows up as a data mismatch, not only as an address mismatch. A reset in mid-frame followed by a fresh sweep shows that the sequence restarts at field 0 and does not resume from where it stopped.

// File: rtl/wfg_pkg.sv
package wfg_pkg;
   // number of fields per frame: weighted bits 2^(b-full_lsb) fields each, low bits one each
   function automatic int field_count(input int bits, input int full_lsb);
      return (1 << (bits - full_lsb)) - 1 + full_lsb;
   endfunction
endpackage

// File: rtl/wfg_scan_ctr.sv
module wfg_scan_ctr #(
   parameter int COLS = 1024,
   parameter int ROWS = 16,
   parameter int NF   = 19,
   localparam int CW  = $clog2(COLS),
   localparam int RW  = $clog2(ROWS),
   localparam int FW  = $clog2(NF)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] col,
   output logic [RW-1:0] row,
   output logic [FW-1:0] field,
   output logic          last_col
);
   logic last_row, last_field;

   assign last_col   = (col == CW'(COLS - 1));
   assign last_row   = (row == RW'(ROWS - 1));
   assign last_field = (field == FW'(NF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col   <= '0;
         row   <= '0;
         field <= '0;
      end else begin
         col <= last_col ? '0 : col + 1'b1;
         if (last_col) begin
            row <= last_row ? '0 : row + 1'b1;
            if (last_row)
               field <= last_field ? '0 : field + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wfg_plane_map.sv
module wfg_plane_map #(
   parameter int BITS     = 8,
   parameter int FULL_LSB = 4,
   parameter int COLS     = 1024,
   parameter int NF       = 19,
   localparam int FW      = $clog2(NF),
   localparam int PW      = $clog2(BITS),
   localparam int WW      = $clog2(COLS + 1)
) (
   input  logic [FW-1:0] field,
   output logic [PW-1:0] plane,
   output logic [WW-1:0] width
);
   always_comb begin
      int base;
      int reps;
      base  = 0;
      plane = '0;
      for (int b = BITS - 1; b >= 0; b--) begin
         reps = (b >= FULL_LSB) ? (1 << (b - FULL_LSB)) : 1;
         if (int'(field) >= base && int'(field) < base + reps)
            plane = PW'(b);
         base = base + reps;
      end
   end

   always_comb begin
      if (int'(plane) >= FULL_LSB)
         width = WW'(COLS);
      else
         width = WW'(COLS >> (FULL_LSB - int'(plane)));
   end
endmodule

// File: rtl/wfg_out_stage.sv
module wfg_out_stage #(
   parameter int LANES = 16,
   parameter int RW    = 4,
   parameter int WW    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] rd_bit,
   input  logic             last_col,
   input  logic [RW-1:0]    row,
   input  logic [WW-1:0]    width,
   output logic [LANES-1:0] sd_out,
   output logic             cp_o,
   output logic             le_o,
   output logic [RW-1:0]    row_sel,
   output logic             load,
   output logic [WW-1:0]    load_width
);
   logic          last_s1;
   logic [RW-1:0] row_s1;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) sd_out[l] <= 1'b0;
         else        sd_out[l] <= rd_bit[l];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cp_o       <= 1'b0;
         last_s1    <= 1'b0;
         row_s1     <= '0;
         load_width <= '0;
         le_o       <= 1'b0;
         row_sel    <= '0;
      end else begin
         cp_o    <= 1'b1;
         last_s1 <= last_col;
         row_s1  <= row;
         if (last_col) load_width <= width;
         le_o    <= last_s1;
         if (last_s1) row_sel <= row_s1;
      end
   end

   assign load = last_s1;
endmodule

// File: rtl/wfg_ea_timer.sv
module wfg_ea_timer #(
   parameter int WW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [WW-1:0] width,
   output logic          ea_o
);
   logic [WW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left <= '0;
         ea_o <= 1'b0;
      end else begin
         ea_o <= (left != '0);
         if (load)
            left <= width;
         else if (left != '0)
            left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/wfg_scan_seq.sv
module wfg_scan_seq #(
   parameter int COLS     = 1024,
   parameter int ROWS     = 16,
   parameter int LANES    = 16,
   parameter int BITS     = 8,
   parameter int FULL_LSB = 4,
   localparam int NF      = wfg_pkg::field_count(BITS, FULL_LSB),
   localparam int CW      = $clog2(COLS),
   localparam int RW      = $clog2(ROWS),
   localparam int FW      = $clog2(NF),
   localparam int PW      = $clog2(BITS),
   localparam int WW      = $clog2(COLS + 1),
   localparam int AW      = PW + RW + CW
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [AW-1:0]    rd_addr,
   input  logic [LANES-1:0] rd_bit,
   output logic [LANES-1:0] sd_out,
   output logic             cp_o,
   output logic             le_o,
   output logic [RW-1:0]    row_sel,
   output logic             ea_o
);
   if ((1 << CW) != COLS) begin : g_bad_cols
      $error("COLS must be a power of two");
   end
   if ((1 << RW) != ROWS || ROWS < 2) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (FULL_LSB >= BITS || FULL_LSB < 0) begin : g_bad_lsb
      $error("FULL_LSB must lie below BITS");
   end
   if ((COLS >> FULL_LSB) < 1) begin : g_bad_width
      $error("COLS too small for the shortest window");
   end

   logic [CW-1:0] col;
   logic [RW-1:0] row;
   logic [FW-1:0] field;
   logic          last_col;
   logic [PW-1:0] plane;
   logic [WW-1:0] width;
   logic          load;
   logic [WW-1:0] load_width;

   wfg_scan_ctr #(.COLS(COLS), .ROWS(ROWS), .NF(NF)) i_ctr (
      .clk(clk), .rst_n(rst_n), .col(col), .row(row), .field(field), .last_col(last_col)
   );

   wfg_plane_map #(.BITS(BITS), .FULL_LSB(FULL_LSB), .COLS(COLS), .NF(NF)) i_map (
      .field(field), .plane(plane), .width(width)
   );

   assign rd_addr = {plane, row, col};

   wfg_out_stage #(.LANES(LANES), .RW(RW), .WW(WW)) i_out (
      .clk(clk), .rst_n(rst_n), .rd_bit(rd_bit), .last_col(last_col), .row(row),
      .width(width), .sd_out(sd_out), .cp_o(cp_o), .le_o(le_o), .row_sel(row_sel),
      .load(load), .load_width(load_width)
   );

   wfg_ea_timer #(.WW(WW)) i_ea (
      .clk(clk), .rst_n(rst_n), .load(load), .width(load_width), .ea_o(ea_o)
   );
endmodule

// File: rtl/wfg_scan_chk.sv
module wfg_scan_chk #(
   parameter int CW = 10,
   parameter int RW = 4,
   parameter int AW = 17
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] rd_addr,
   input logic          cp_o,
   input logic          le_o,
   input logic [RW-1:0] row_sel,
   input logic          ea_o
);
   logic          armed;
   logic [CW-1:0] col;
   logic [RW-1:0] row;

   assign col = rd_addr[CW-1:0];
   assign row = rd_addr[CW+RW-1:CW];

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_col_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> col == CW'($past(col) + 1'b1));

   assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && col == '0) |-> row == RW'($past(row) + 1'b1));

   assert_cp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cp_o |=> cp_o);

   assert_le_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      le_o |=> !le_o);

   assert_rowsel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !le_o) |-> $stable(row_sel));

   assert_ea_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $rose(ea_o)) |-> $past(le_o));
endmodule

bind wfg_scan_seq wfg_scan_chk #(.CW(CW), .RW(RW), .AW(AW)) i_chk (
   .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .cp_o(cp_o), .le_o(le_o),
   .row_sel(row_sel), .ea_o(ea_o)
);

// File: tb/test_wfg_scan_seq.sv
module test_wfg_scan_seq;
   localparam int CLK_PERIOD = 10;
   localparam int C  = 16;
   localparam int R  = 4;
   localparam int L  = 2;
   localparam int NF = 19;
   localparam int AW = 3 + 2 + 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] rd_addr;
   logic [L-1:0]  rd_bit;
   logic [L-1:0]  sd_out;
   logic          cp_o, le_o, ea_o;
   logic [1:0]    row_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wfg_scan_seq #(.COLS(C), .ROWS(R), .LANES(L), .BITS(8), .FULL_LSB(4)) i_wfg_scan_seq (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_bit(rd_bit), .sd_out(sd_out),
      .cp_o(cp_o), .le_o(le_o), .row_sel(row_sel), .ea_o(ea_o)
   );

   function automatic logic mem_bit(input int a, input int lane);
      int v;
      v = (a * (lane + 5)) ^ (a >> 2);
      return ^v[15:0];
   endfunction

   function automatic logic [L-1:0] mem_word(input int a);
      logic [L-1:0] w;
      for (int l = 0; l < L; l++) w[l] = mem_bit(a, l);
      return w;
   endfunction

   always_comb rd_bit = mem_word(int'(rd_addr));

   function automatic int exp_plane(input int f);
      if (f < 8)  return 7;
      if (f < 12) return 6;
      if (f < 14) return 5;
      return 18 - f;
   endfunction

   function automatic int exp_width(input int p);
      return (p >= 4) ? C : (C >> (4 - p));
   endfunction

   function automatic int exp_addr(input int t);
      int f, r, c;
      c = t % C;
      r = (t / C) % R;
      f = (t / (C * R)) % NF;
      return exp_plane(f) * (R * C) + r * C + c;
   endfunction

   task automatic check(input string req, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_reset();
      check("R1 sd_out", sd_out == '0, int'(sd_out), 0);
      check("R1 cp_o", cp_o == 1'b0, int'(cp_o), 0);
      check("R1 le_o", le_o == 1'b0, int'(le_o), 0);
      check("R1 row_sel", row_sel == '0, int'(row_sel), 0);
      check("R1 ea_o", ea_o == 1'b0, int'(ea_o), 0);
      check("R1 rd_addr", int'(rd_addr) == 7 * R * C, int'(rd_addr), 7 * R * C);
   endtask

   // t counts cycles since reset release; t=0 holds the reset counter values
   task automatic sweep(input int ncyc);
      for (int t = 0; t < ncyc; t++) begin
         int k, e, d, ea_e, rs_e;
         if (t > 0) @(negedge clk);
         #1;
         e = exp_addr(t);
         check("R2/R3/R4 rd_addr", int'(rd_addr) == e, int'(rd_addr), e);
         if (t >= 1) begin
            e = int'(mem_word(exp_addr(t - 1)));
            check("R5 sd_out", int'(sd_out) == e, int'(sd_out), e);
         end
         e = (t >= 1) ? 1 : 0;
         check("R5 cp_o", int'(cp_o) == e, int'(cp_o), e);
         e = (t >= 2 && ((t - 2) % C) == C - 1) ? 1 : 0;
         check("R6 le_o", int'(le_o) == e, int'(le_o), e);
         rs_e = 0;
         if (t - 2 >= C - 1) begin
            k = ((t - 2 - (C - 1)) / C) * C + C - 1;
            rs_e = (k / C) % R;
         end
         check("R6 row_sel", int'(row_sel) == rs_e, int'(row_sel), rs_e);
         ea_e = 0;
         if (t - 3 >= C - 1) begin
            k = ((t - 3 - (C - 1)) / C) * C + C - 1;
            d = t - k - 2;
            ea_e = (d >= 1 && d <= exp_width(exp_plane((k / (C * R)) % NF))) ? 1 : 0;
         end
         check("R7/R8 ea_o", int'(ea_o) == ea_e, int'(ea_o), ea_e);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check_reset();
      @(negedge clk);
      rst_n = 1'b1;
      sweep(3 * NF * R * C + 40);
      // mid-frame reset: sequence must restart at field 0
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      check_reset();
      @(negedge clk);
      rst_n = 1'b1;
      sweep(NF * R * C + 40);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule